// File: doc/BRIEF.md
# Priority Round-Robin Crossbar Matching Scheduler

This block computes a crossbar configuration for an N-port input-queued switch. Each input holds a separate queue for every output, and each of those queues is split into L priority classes. The block reads a flag for every (input, output, class) that says whether that queue holds a cell. It then runs a fixed number of request/grant/accept iterations and returns a conflict-free set of input-to-output connections, together with the class each connection serves.

For every output, each input asks for service at the highest class among its non-empty queues for that output. An output first keeps only the contenders at the highest class it sees. It then picks one of them with a round-robin pointer that belongs to that output and that class. Inputs settle competing grants the same way, using their own per-class accept pointers. A pointer moves only when a match is made in the first iteration. That match sends the port just served to the back of the order, which spreads the pointers apart under load.

A schedule is launched with a one-cycle start pulse. The occupancy flags are captured at that edge. One iteration runs per clock, and the result is flagged by a one-cycle done pulse. Queue storage and cell transfer belong to the surrounding switch.

Top module: `prr_sched`

## Requirements
- R1: While reset is held, and after reset is released, `busy_o`, `done_o` and every bit of `match_o` are 0, and every grant and accept pointer points at index 0.
- R2: Occupancy flag for input i, output j, class l sits at bit (i*N+j)*L+l of `occ_i`, where class 0 is lowest and L-1 highest. The pair requests at the highest set class. A pair with no flag set is never matched. A matched pair reports its request class in `match_lvl_o` bits (i*N+j)*LW +: LW, and unmatched pairs report 0.
- R3: `match_o` bit i*N+j marks input i connected to output j. No input and no output is ever connected more than once.
- R4: An output grants only among its contenders at the highest requested class, where contenders are inputs still unmatched in the schedule.
- R5: Among contenders at the winning class, an output grants the first input found scanning upward, with wrap, from its pointer for that class.
- R6: An input receiving several grants accepts only among those at the highest class. Among those it takes the first output found scanning upward, with wrap, from its accept pointer for that class.
- R7: When a match is made in the first iteration, the output's grant pointer for the matched class moves to one past the matched input, modulo N. The input's accept pointer for that class moves to one past the matched output. Matches made in later iterations, and pointers of other classes, leave pointers unchanged. The new pointers apply from the next schedule.
- R8: Take the edge that samples `start_i` while idle. `busy_o` is high for the ITERS cycles after that edge. `done_o` is then high for exactly one cycle, with `busy_o` low and the result valid.
- R9: `start_i` and any change of `occ_i` while `busy_o` is high have no effect. The running schedule's result is unchanged, and no extra schedule follows.
- R10: With ITERS >= N the result is maximal: no requesting pair is left with both its input and its output unconnected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a schedule (sampled while idle) |
| occ_i | input | N*N*L | Per input/output/class non-empty flags |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle result strobe |
| match_o | output | N*N | Connection matrix, bit i*N+j |
| match_lvl_o | output | N*N*LW | Served class per pair |

## Verification
The bench goes after the class-before-pointer ordering: an output with a high-class request from a far input and a low-class request from the input under its pointer must pick the far one. A design that let the pointer decide first would serve the low class. Pointer independence across classes is probed by advancing one class's pointer and then loading the other class. A single shared pointer would rotate to the wrong input. A case where a connection is made only in the second iteration catches pointers that move on late matches, because the following schedules would then start from the wrong positions. Start pulses and occupancy changes during a running schedule check that captured requests are not overwritten and that no second result appears.

// File: rtl/prr_pkg.sv
package prr_pkg;

    localparam int unsigned PRR_DEF_PORTS  = 4;
    localparam int unsigned PRR_DEF_LEVELS = 4;

    typedef enum logic [0:0] {
        SCH_IDLE = 1'b0,
        SCH_RUN  = 1'b1
    } sched_state_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prr_req_level.sv
module prr_req_level #(
    parameter int unsigned N  = 4,
    parameter int unsigned L  = 4,
    parameter int unsigned LW = 2
) (
    input  logic [N*N*L-1:0]          occ,
    output logic [N*N-1:0]            req_v,
    output logic [N*N-1:0][LW-1:0]    req_lvl
);
    localparam int unsigned NP = N * N;

    always_comb begin
        for (int p = 0; p < NP; p++) begin
            req_v[p]   = |occ[p*L +: L];
            req_lvl[p] = '0;
            for (int l = 0; l < L; l++) begin
                if (occ[p*L + l]) begin
                    req_lvl[p] = LW'(l);
                end
            end
        end
    end
endmodule

// File: rtl/prr_lvl_rr_arb.sv
module prr_lvl_rr_arb #(
    parameter int unsigned N  = 4,
    parameter int unsigned L  = 4,
    parameter int unsigned LW = 2,
    parameter int unsigned IW = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N-1:0]            cand,
    input  logic [N-1:0][LW-1:0]    cand_lvl,
    input  logic                    upd_en,
    input  logic [IW-1:0]           upd_idx,
    input  logic [LW-1:0]           upd_lvl,
    output logic                    win_v,
    output logic [IW-1:0]           win_idx,
    output logic [LW-1:0]           win_lvl
);
    logic [L-1:0][IW-1:0] ptr_q;
    logic [LW-1:0]        top_lvl;
    logic [IW-1:0]        start_ptr;
    int                   pos;

    // class selection first, then the pointer of that class
    always_comb begin
        top_lvl = '0;
        for (int k = 0; k < N; k++) begin
            if (cand[k] && (cand_lvl[k] > top_lvl)) begin
                top_lvl = cand_lvl[k];
            end
        end
        start_ptr = ptr_q[top_lvl];
        win_v     = 1'b0;
        win_idx   = '0;
        pos       = 0;
        for (int k = 0; k < N; k++) begin
            pos = (int'(start_ptr) + k) % N;
            if (!win_v && cand[pos] && (cand_lvl[pos] == top_lvl)) begin
                win_v   = 1'b1;
                win_idx = IW'(pos);
            end
        end
        win_lvl = top_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (upd_en) begin
            ptr_q[upd_lvl] <= (upd_idx == IW'(N - 1)) ? '0 : upd_idx + 1'b1;
        end
    end
endmodule

// File: rtl/prr_sched.sv
module prr_sched
    import prr_pkg::*;
#(
    parameter int unsigned N     = PRR_DEF_PORTS,
    parameter int unsigned L     = PRR_DEF_LEVELS,
    parameter int unsigned ITERS = PRR_DEF_PORTS,
    parameter int unsigned LW    = idx_width(L)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [N*N*L-1:0]     occ_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [N*N-1:0]       match_o,
    output logic [N*N*LW-1:0]    match_lvl_o
);
    localparam int unsigned IW   = idx_width(N);
    localparam int unsigned IT_W = idx_width(ITERS);

    sched_state_e                  state_q;
    logic [IT_W-1:0]               iter_q;
    logic                          done_q;
    logic [N*N*L-1:0]              occ_q;
    logic [N-1:0][N-1:0]           match_q;
    logic [N-1:0][N-1:0][LW-1:0]   mlvl_q;

    // first-iteration pointer updates, per output and per input
    logic [N-1:0]                  gupd_v_q,   aupd_v_q;
    logic [N-1:0][IW-1:0]          gupd_idx_q, aupd_idx_q;
    logic [N-1:0][LW-1:0]          gupd_lvl_q, aupd_lvl_q;

    logic [N*N-1:0]                req_v;
    logic [N*N-1:0][LW-1:0]        req_lvl;
    logic [N-1:0]                  in_busy, out_busy;

    logic [N-1:0][N-1:0]           g_cand;     // [output][input]
    logic [N-1:0][N-1:0][LW-1:0]   g_cand_lvl;
    logic [N-1:0]                  g_v;
    logic [N-1:0][IW-1:0]          g_idx;
    logic [N-1:0][LW-1:0]          g_lvl;

    logic [N-1:0][N-1:0]           a_cand;     // [input][output]
    logic [N-1:0][N-1:0][LW-1:0]   a_cand_lvl;
    logic [N-1:0]                  a_v;
    logic [N-1:0][IW-1:0]          a_idx;
    logic [N-1:0][LW-1:0]          a_lvl;

    prr_req_level #(.N(N), .L(L), .LW(LW)) u_req (
        .occ     (occ_q),
        .req_v   (req_v),
        .req_lvl (req_lvl)
    );

    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_busy[i] = |match_q[i];
        end
        for (int j = 0; j < N; j++) begin
            out_busy[j] = 1'b0;
            for (int i = 0; i < N; i++) begin
                out_busy[j] = out_busy[j] | match_q[i][j];
            end
        end
    end

    // grant stage inputs
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                g_cand[j][i]     = req_v[i*N + j] && !in_busy[i] && !out_busy[j];
                g_cand_lvl[j][i] = req_lvl[i*N + j];
            end
        end
    end

    generate
        for (genvar gj = 0; gj < N; gj++) begin : g_out_arb
            prr_lvl_rr_arb #(.N(N), .L(L), .LW(LW), .IW(IW)) u_garb (
                .clk      (clk),
                .rst      (rst),
                .cand     (g_cand[gj]),
                .cand_lvl (g_cand_lvl[gj]),
                .upd_en   (done_q && gupd_v_q[gj]),
                .upd_idx  (gupd_idx_q[gj]),
                .upd_lvl  (gupd_lvl_q[gj]),
                .win_v    (g_v[gj]),
                .win_idx  (g_idx[gj]),
                .win_lvl  (g_lvl[gj])
            );
        end
    endgenerate

    // accept stage inputs: grants addressed to each input
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                a_cand[i][j]     = g_v[j] && (g_idx[j] == IW'(i));
                a_cand_lvl[i][j] = g_lvl[j];
            end
        end
    end

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_in_arb
            prr_lvl_rr_arb #(.N(N), .L(L), .LW(LW), .IW(IW)) u_aarb (
                .clk      (clk),
                .rst      (rst),
                .cand     (a_cand[gi]),
                .cand_lvl (a_cand_lvl[gi]),
                .upd_en   (done_q && aupd_v_q[gi]),
                .upd_idx  (aupd_idx_q[gi]),
                .upd_lvl  (aupd_lvl_q[gi]),
                .win_v    (a_v[gi]),
                .win_idx  (a_idx[gi]),
                .win_lvl  (a_lvl[gi])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SCH_IDLE;
            iter_q     <= '0;
            done_q     <= 1'b0;
            occ_q      <= '0;
            match_q    <= '0;
            mlvl_q     <= '0;
            gupd_v_q   <= '0;
            gupd_idx_q <= '0;
            gupd_lvl_q <= '0;
            aupd_v_q   <= '0;
            aupd_idx_q <= '0;
            aupd_lvl_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SCH_IDLE: begin
                    if (start_i) begin
                        occ_q    <= occ_i;
                        match_q  <= '0;
                        mlvl_q   <= '0;
                        iter_q   <= '0;
                        gupd_v_q <= '0;
                        aupd_v_q <= '0;
                        state_q  <= SCH_RUN;
                    end
                end
                SCH_RUN: begin
                    for (int i = 0; i < N; i++) begin
                        if (a_v[i]) begin
                            match_q[i][a_idx[i]] <= 1'b1;
                            mlvl_q[i][a_idx[i]]  <= a_lvl[i];
                            if (iter_q == '0) begin
                                aupd_v_q[i]          <= 1'b1;
                                aupd_idx_q[i]        <= a_idx[i];
                                aupd_lvl_q[i]        <= a_lvl[i];
                                gupd_v_q[a_idx[i]]   <= 1'b1;
                                gupd_idx_q[a_idx[i]] <= IW'(i);
                                gupd_lvl_q[a_idx[i]] <= a_lvl[i];
                            end
                        end
                    end
                    if (iter_q == IT_W'(ITERS - 1)) begin
                        state_q <= SCH_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                default: state_q <= SCH_IDLE;
            endcase
        end
    end

    assign busy_o      = (state_q == SCH_RUN);
    assign done_o      = done_q;
    assign match_o     = match_q;
    assign match_lvl_o = mlvl_q;

endmodule

// File: rtl/prr_sched_chk.sv
module prr_sched_chk #(
    parameter int unsigned N     = 4,
    parameter int unsigned L     = 4,
    parameter int unsigned ITERS = 4,
    parameter int unsigned LW    = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               start_i,
    input logic [N*N*L-1:0]   occ_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [N*N-1:0]     match_o,
    input logic [N*N*LW-1:0]  match_lvl_o
);
    logic [N*N*L-1:0] cap_q;
    int unsigned      busy_cnt_q;
    logic [N-1:0]     row_any, col_any;
    logic [N-1:0][N-1:0] col_bits;
    logic             lvl_bad, left_open;
    int               hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q      <= '0;
            busy_cnt_q <= 0;
        end else begin
            if (start_i && !busy_o) cap_q <= occ_i;
            busy_cnt_q <= busy_o ? busy_cnt_q + 1 : 0;
        end
    end

    always_comb begin
        lvl_bad   = 1'b0;
        left_open = 1'b0;
        for (int i = 0; i < N; i++) begin
            row_any[i] = |match_o[i*N +: N];
            for (int j = 0; j < N; j++) col_bits[j][i] = match_o[i*N + j];
        end
        for (int j = 0; j < N; j++) col_any[j] = |col_bits[j];
        for (int p = 0; p < N*N; p++) begin
            hi = -1;
            for (int l = 0; l < L; l++) if (cap_q[p*L + l]) hi = l;
            if (match_o[p] && (hi < 0 || int'(match_lvl_o[p*LW +: LW]) != hi)) lvl_bad = 1'b1;
            if (!match_o[p] && match_lvl_o[p*LW +: LW] != '0) lvl_bad = 1'b1;
            if (hi >= 0 && !row_any[p / N] && !col_any[p % N]) left_open = 1'b1;
        end
    end

    generate
        for (genvar k = 0; k < N; k++) begin : g_one
            assert_row_single_R3: assert property (@(posedge clk) disable iff (rst)
                $onehot0(match_o[k*N +: N]));
            assert_col_single_R3: assert property (@(posedge clk) disable iff (rst)
                $onehot0(col_bits[k]));
        end
        if (ITERS >= N) begin : g_max
            assert_maximal_R10: assert property (@(posedge clk) disable iff (rst)
                done_o |-> !left_open);
        end
    endgenerate

    assert_class_match_R2: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !lvl_bad);

    assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_cnt_q == ITERS && !busy_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind prr_sched prr_sched_chk #(.N(N), .L(L), .ITERS(ITERS), .LW(LW)) u_prr_chk (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .occ_i       (occ_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .match_o     (match_o),
    .match_lvl_o (match_lvl_o)
);

// File: tb/prr_sched_bench.sv
module prr_sched_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 4;
    localparam int L     = 4;
    localparam int ITERS = 4;
    localparam int LW    = 2;
    localparam int NN    = N * N;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start_i = 1'b0;
    logic [NN*L-1:0]    occ_i = '0;
    logic               busy_o, done_o;
    logic [NN-1:0]      match_o;
    logic [NN*LW-1:0]   match_lvl_o;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [NN-1:0]    m;
        logic [NN*LW-1:0] ml;
        string            tag;
    } exp_t;
    exp_t sbq[$];

    int gptr[N][L];
    int aptr[N][L];

    prr_sched #(.N(N), .L(L), .ITERS(ITERS)) u_prr_sched (
        .clk(clk), .rst(rst), .start_i(start_i), .occ_i(occ_i),
        .busy_o(busy_o), .done_o(done_o), .match_o(match_o), .match_lvl_o(match_lvl_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // reference model built from the requirements
    task automatic model(input logic [NN*L-1:0] occ, output logic [NN-1:0] m,
                         output logic [NN*LW-1:0] ml);
        int  rl[N][N];
        bit  rv[N][N];
        bit  im[N];
        bit  om[N];
        int  gw[N];
        int  gi[N], gl[N], ai[N], al[N];
        int  best, p, pick;
        m = '0; ml = '0;
        for (int i = 0; i < N; i++) begin
            im[i] = 0; om[i] = 0; gi[i] = -1; ai[i] = -1; gl[i] = 0; al[i] = 0;
            for (int j = 0; j < N; j++) begin
                rv[i][j] = 0; rl[i][j] = 0;
                for (int l = 0; l < L; l++)
                    if (occ[(i*N+j)*L + l]) begin rv[i][j] = 1; rl[i][j] = l; end
            end
        end
        for (int it = 0; it < ITERS; it++) begin
            for (int j = 0; j < N; j++) begin
                gw[j] = -1;
                if (!om[j]) begin
                    best = -1;
                    for (int i = 0; i < N; i++)
                        if (rv[i][j] && !im[i] && rl[i][j] > best) best = rl[i][j];
                    if (best >= 0)
                        for (int k = 0; k < N; k++) begin
                            p = (gptr[j][best] + k) % N;
                            if (gw[j] < 0 && rv[p][j] && !im[p] && rl[p][j] == best) gw[j] = p;
                        end
                end
            end
            for (int i = 0; i < N; i++) begin
                if (!im[i]) begin
                    best = -1;
                    for (int j = 0; j < N; j++)
                        if (gw[j] == i && rl[i][j] > best) best = rl[i][j];
                    if (best >= 0) begin
                        pick = -1;
                        for (int k = 0; k < N; k++) begin
                            p = (aptr[i][best] + k) % N;
                            if (pick < 0 && gw[p] == i && rl[i][p] == best) pick = p;
                        end
                        im[i] = 1; om[pick] = 1;
                        m[i*N + pick] = 1'b1;
                        ml[(i*N + pick)*LW +: LW] = LW'(best);
                        if (it == 0) begin
                            gi[pick] = i; gl[pick] = best;
                            ai[i] = pick; al[i] = best;
                        end
                    end
                end
            end
        end
        for (int x = 0; x < N; x++) begin
            if (gi[x] >= 0) gptr[x][gl[x]] = (gi[x] + 1) % N;
            if (ai[x] >= 0) aptr[x][al[x]] = (ai[x] + 1) % N;
        end
    endtask

    // monitor: pops expected results when the design strobes done
    always @(negedge clk) begin
        if (!rst && done_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R9", "unexpected done", 64'(match_o), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(match_o == e.m, e.tag, "match", 64'(match_o), 64'(e.m));
                check(match_lvl_o == e.ml, e.tag, "class", 64'(match_lvl_o), 64'(e.ml));
            end
        end
    end

    function automatic logic [NN*L-1:0] put(input logic [NN*L-1:0] o, input int i,
                                            input int j, input int l);
        logic [NN*L-1:0] r;
        r = o;
        r[(i*N+j)*L + l] = 1'b1;
        return r;
    endfunction

    // driver: push expectation, launch, check R8 timing
    task automatic sched(input logic [NN*L-1:0] occ, input string tag,
                         input bit poke_busy, input logic [NN*L-1:0] occ2);
        exp_t e;
        model(occ, e.m, e.ml);
        e.tag = tag;
        sbq.push_back(e);
        occ_i = occ;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R8", "busy after start", {busy_o, done_o}, 2'b10);
        if (poke_busy) begin   // R9: start and new occupancy while running
            occ_i = occ2;
            start_i = 1'b1;
        end
        repeat (ITERS - 1) @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !done_o, "R8", "busy at last iteration", {busy_o, done_o}, 2'b10);
        @(negedge clk);
        check(!busy_o && done_o, "R8", "done strobe", {busy_o, done_o}, 2'b01);
        @(negedge clk);
        check(!done_o, "R8", "done one cycle", 64'(done_o), 0);
        if (poke_busy) begin
            int extra = 0;
            repeat (ITERS + 2) begin
                @(negedge clk);
                if (busy_o || done_o) extra++;
            end
            check(extra == 0, "R9", "no schedule from ignored start", extra, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        check(1'b0, "R8", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [NN*L-1:0] o;
        for (int a = 0; a < N; a++)
            for (int b = 0; b < L; b++) begin gptr[a][b] = 0; aptr[a][b] = 0; end

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o && match_o == '0, "R1", "state in reset",
              {busy_o, done_o, match_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && match_o == '0, "R1", "state after reset",
              {busy_o, done_o, match_o}, 0);

        // R8: empty occupancy still completes, no connections
        sched('0, "R8 empty", 1'b0, '0);

        // R2: highest set class wins, pair (0,0) at class 2
        o = put(put('0, 0, 0, 0), 0, 0, 2);
        sched(o, "R2", 1'b0, '0);

        // R4: class 3 from input 2 beats class 0 from input 0 under the pointer
        o = put(put('0, 0, 1, 0), 2, 1, 3);
        sched(o, "R4", 1'b0, '0);

        // R5 R7: all inputs to output 0 at class 1, rotating grants
        o = '0;
        for (int i = 0; i < N; i++) o = put(o, i, 0, 1);
        sched(o, "R5 R7 rot0", 1'b0, '0);
        sched(o, "R5 R7 rot1", 1'b0, '0);

        // R7: class 2 pointer untouched by class 1 rotation -> input 0
        o = '0;
        for (int i = 0; i < N; i++) o = put(o, i, 0, 2);
        sched(o, "R7 per-class pointer", 1'b0, '0);

        // R6: one input granted by all outputs, highest class accepted
        o = '0;
        for (int j = 0; j < N; j++) o = put(o, 3, j, 0);
        o = put(o, 3, 2, 3);
        sched(o, "R6 class accept", 1'b0, '0);
        o = '0;
        for (int j = 0; j < N; j++) o = put(o, 3, j, 0);
        sched(o, "R6 accept pointer", 1'b0, '0);
        sched(o, "R6 accept rotate", 1'b0, '0);

        // R7 R10: second-iteration match leaves its pointers alone
        o = '0;
        for (int i = 0; i < 2; i++)
            for (int j = 0; j < 2; j++) o = put(o, i, j, 0);
        sched(o, "R7 R10 late match", 1'b0, '0);
        sched(o, "R7 R10 follow-up", 1'b0, '0);

        // R9: start and occupancy change while busy are ignored
        o = put('0, 1, 3, 1);
        sched(o, "R9", 1'b1, '1);

        // R3 R10: full load
        sched('1, "R3 R10 full", 1'b0, '0);

        // mixed patterns
        for (int t = 0; t < 60; t++) begin
            o = '0;
            for (int b = 0; b < NN*L; b++) if (($urandom % 3) == 0) o[b] = 1'b1;
            sched(o, "R2 R3 R4 R5 R6 R7 R10 mix", 1'b0, '0);
        end

        check(sbq.size() == 0, "R8", "all results seen", sbq.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule